// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

When a load issues, this block searches the stores that came before it in program order for any whose bytes overlap the load. If the nearest such store holds every byte the load needs, the block returns those bytes as forwarded data. If the nearest overlapping store holds only some of the bytes, the load cannot finish. The block then asks for the load to be rescheduled and records a stall, which stays until that store has been written to memory. If no older store overlaps the load, the load goes to memory.

The store queue is circular. Its contents come in as flat vectors with one field per slot: address, size in bytes, an uncacheable bit, data (little-endian) and sequence number. Each load brings the store-queue index that was captured when the load was allocated. The block looks only at slots older than that index, down to the writeback pointer. Each load produces exactly one outcome, registered one cycle after the load is presented. The stall record is held until a store-completion event with the matching sequence number arrives. That event releases the stall and emits a replay pulse carrying the stalled load's queue index.

Top module: `stlf_checker`

## Requirements
- R1: The search covers slots `ld_sq_idx-1`, `ld_sq_idx-2`, … down to and including `sq_wb_ptr`, with indices wrapping modulo the queue depth. When `ld_sq_idx` equals `sq_wb_ptr`, no slot is searched.
- R2: A slot whose size field is zero, or whose uncacheable bit is set, never matches a load.
- R3: When the load's byte range `[ld_addr, ld_addr+ld_size)` lies entirely inside a store's range, `fwd_valid` pulses one cycle after `ld_valid`. `fwd_data` byte b then equals store data byte `(ld_addr - store_addr) + b` for every b below `ld_size`, and every byte at or above `ld_size` is zero.
- R4: Among the searched slots, the nearest older slot that overlaps the load (lowest distance below `ld_sq_idx`) alone decides the outcome. Slots further away are ignored.
- R5: When the deciding store overlaps the load without containing it, `resched` pulses one cycle after `ld_valid`, with `fwd_valid` and `mem_go` low. If this load is admitted to the stall record (see R7), `stalled` rises and `stall_seq` shows that store's sequence number.
- R6: When no searched slot overlaps the load, `mem_go` pulses one cycle after `ld_valid`.
- R7: A partial match replaces the stall record (`stall_seq`, `stall_lq_idx`) only if the block is not stalled, or if the new load's `ld_seq` is numerically smaller (older) than the recorded load's. Otherwise the record is unchanged.
- R8: An uncacheable load (`ld_uncache`=1) with `ld_at_head`=0 gets `resched` and neither `mem_go` nor `fwd_valid`, and it does not change the stall record. With `ld_at_head`=1 it is searched like any other load.
- R9: When `done_valid` is high, the block is stalled, and `done_seq` equals `stall_seq`, the next cycle shows `stalled` low and a one-cycle `replay_valid` with `replay_lq_idx` equal to the recorded load index. A completion event with any other sequence number leaves the stall in place.
- R10: After reset, every output is zero.
- R11: For every cycle with `ld_valid` high, exactly one of `fwd_valid`, `mem_go` and `resched` is high in the following cycle. All three are low after a cycle without a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SIZE_W | Load size in bytes |
| ld_sq_idx | input | IDX_W | Store-queue index captured when the load was allocated |
| ld_seq | input | SEQ_W | Load sequence number (smaller is older) |
| ld_lq_idx | input | LQ_W | Load-queue slot of the load |
| ld_uncache | input | 1 | Load is uncacheable |
| ld_at_head | input | 1 | Load is at the load-queue head and ready to commit |
| sq_wb_ptr | input | IDX_W | Oldest store slot not yet written back |
| sq_addr | input | SQ_DEPTH*ADDR_W | Per-slot store address |
| sq_size | input | SQ_DEPTH*SIZE_W | Per-slot store size; 0 means data not yet written |
| sq_uncache | input | SQ_DEPTH | Per-slot uncacheable bit |
| sq_data | input | SQ_DEPTH*DATA_W | Per-slot store data, little-endian |
| sq_seq | input | SQ_DEPTH*SEQ_W | Per-slot store sequence number |
| done_valid | input | 1 | A store finished its writeback |
| done_seq | input | SEQ_W | Sequence number of that store |
| fwd_valid | output | 1 | Load data supplied from a store |
| fwd_data | output | DATA_W | Forwarded bytes, zero above the load size |
| mem_go | output | 1 | Load should access memory |
| resched | output | 1 | Load must be rescheduled |
| stalled | output | 1 | A partial-overlap stall is recorded |
| stall_seq | output | SEQ_W | Sequence number of the store causing the stall |
| stall_lq_idx | output | LQ_W | Load-queue slot of the stalled load |
| replay_valid | output | 1 | Stall released; replay the recorded load |
| replay_lq_idx | output | LQ_W | Load-queue slot to replay |

## Verification
Each load outcome (`fwd_valid`, `fwd_data`, `mem_go`, `resched`) is registered once. It is therefore due one edge after the cycle in which `ld_valid` is high. The bench drives the load just after a falling edge and reads the result at the next falling edge, then checks that the pulse has gone one cycle later.

Changes to the stall record and the replay pulse also take one edge, counted from the load or the completion event. The bench therefore reads `stalled`, `stall_seq`, `stall_lq_idx` and `replay_valid` at that same falling edge, and again one cycle later to confirm that the replay pulse has ended.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_FULL = 2'd1,
      HIT_PART = 2'd2
   } hit_kind_e;
endpackage

// File: rtl/sfc_slot_cmp.sv
module sfc_slot_cmp
   import sfc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SIZE_W = 4
) (
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [SIZE_W-1:0] st_size,
   input  logic              st_uncache,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [SIZE_W-1:0] ld_size,
   output hit_kind_e         kind
);
   localparam int EXT_W = ADDR_W + 1;

   logic [ADDR_W:0] st_lo, st_hi, ld_lo, ld_hi;

   assign st_lo = {1'b0, st_addr};
   assign ld_lo = {1'b0, ld_addr};
   assign st_hi = st_lo + EXT_W'(st_size);
   assign ld_hi = ld_lo + EXT_W'(ld_size);

   // R2: unwritten (size 0) or uncacheable stores never match
   always_comb begin
      kind = HIT_NONE;
      if (st_size != '0 && !st_uncache) begin
         if (ld_lo >= st_lo && ld_hi <= st_hi)
            kind = HIT_FULL;
         else if (ld_lo < st_hi && ld_hi > st_lo)
            kind = HIT_PART;
      end
   end
endmodule

// File: rtl/sfc_scan.sv
module sfc_scan
   import sfc_pkg::*;
#(
   parameter int DEPTH      = 8,
   parameter int ADDR_W     = 16,
   parameter int SIZE_W     = 4,
   parameter int DATA_BYTES = 8,
   parameter int SEQ_W      = 8,
   localparam int IDX_W     = $clog2(DEPTH),
   localparam int OFF_W     = $clog2(DATA_BYTES),
   localparam int DATA_W    = DATA_BYTES * 8
) (
   input  logic [ADDR_W-1:0]       ld_addr,
   input  logic [SIZE_W-1:0]       ld_size,
   input  logic [IDX_W-1:0]        start_idx,
   input  logic [IDX_W-1:0]        wb_ptr,
   input  logic [DEPTH*ADDR_W-1:0] sq_addr_f,
   input  logic [DEPTH*SIZE_W-1:0] sq_size_f,
   input  logic [DEPTH-1:0]        sq_unc,
   input  logic [DEPTH*DATA_W-1:0] sq_data_f,
   input  logic [DEPTH*SEQ_W-1:0]  sq_seq_f,
   output logic                    found,
   output hit_kind_e               kind,
   output logic [SEQ_W-1:0]        hit_seq,
   output logic [OFF_W-1:0]        off,
   output logic [DATA_W-1:0]       fwd_data
);
   // R1: number of slots between the load snapshot and the writeback pointer
   logic [IDX_W-1:0] span;
   assign span = start_idx - wb_ptr;

   hit_kind_e        kinds [DEPTH];
   logic [IDX_W-1:0] slot  [DEPTH];

   // one comparator per distance below the snapshot index
   for (genvar k = 0; k < DEPTH; k++) begin : g_dist
      assign slot[k] = start_idx - IDX_W'(k + 1);
      sfc_slot_cmp #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_cmp (
         .st_addr   (sq_addr_f[slot[k]*ADDR_W +: ADDR_W]),
         .st_size   (sq_size_f[slot[k]*SIZE_W +: SIZE_W]),
         .st_uncache(sq_unc[slot[k]]),
         .ld_addr   (ld_addr),
         .ld_size   (ld_size),
         .kind      (kinds[k])
      );
   end

   // R4: the nearest overlapping slot wins, so walk from farthest to nearest
   logic [IDX_W-1:0] sel;
   always_comb begin
      found = 1'b0;
      kind  = HIT_NONE;
      sel   = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         if (k < int'(span) && kinds[k] != HIT_NONE) begin
            found = 1'b1;
            kind  = kinds[k];
            sel   = slot[k];
         end
      end
   end

   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] sel_data, shifted;

   assign sel_addr = sq_addr_f[sel*ADDR_W +: ADDR_W];
   assign sel_data = sq_data_f[sel*DATA_W +: DATA_W];
   assign hit_seq  = sq_seq_f[sel*SEQ_W +: SEQ_W];
   assign off      = ld_addr[OFF_W-1:0] - sel_addr[OFF_W-1:0];
   assign shifted  = sel_data >> {off, 3'b000};

   // R3: keep only the bytes the load asked for
   always_comb begin
      for (int b = 0; b < DATA_BYTES; b++)
         fwd_data[b*8 +: 8] = (b < int'(ld_size)) ? shifted[b*8 +: 8] : 8'h00;
   end
endmodule

// File: rtl/sfc_stall_track.sv
module sfc_stall_track #(
   parameter int SEQ_W = 8,
   parameter int LQ_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             part_valid,
   input  logic [SEQ_W-1:0] part_ld_seq,
   input  logic [LQ_W-1:0]  part_lq_idx,
   input  logic [SEQ_W-1:0] part_st_seq,
   input  logic             done_valid,
   input  logic [SEQ_W-1:0] done_seq,
   output logic             stalled,
   output logic [SEQ_W-1:0] stall_seq,
   output logic [LQ_W-1:0]  stall_lq_idx,
   output logic             replay_valid,
   output logic [LQ_W-1:0]  replay_lq_idx
);
   logic [SEQ_W-1:0] stall_ld_seq;
   logic take, release_now;

   // R7: only the oldest partially matched load is kept
   assign take        = part_valid && (!stalled || part_ld_seq < stall_ld_seq);
   // R9: completion of the recorded store releases the stall
   assign release_now = done_valid && stalled && done_seq == stall_seq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stalled       <= 1'b0;
         stall_seq     <= '0;
         stall_ld_seq  <= '0;
         stall_lq_idx  <= '0;
         replay_valid  <= 1'b0;
         replay_lq_idx <= '0;
      end else begin
         replay_valid  <= release_now;
         replay_lq_idx <= release_now ? stall_lq_idx : '0;
         if (take) begin
            stalled      <= 1'b1;
            stall_seq    <= part_st_seq;
            stall_ld_seq <= part_ld_seq;
            stall_lq_idx <= part_lq_idx;
         end else if (release_now) begin
            stalled <= 1'b0;
         end
      end
   end

   p_keep_older_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stalled && part_valid && !(part_ld_seq < stall_ld_seq) && !done_valid
      |=> $stable(stall_seq) && $stable(stall_lq_idx));

   p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid && stalled && done_seq == stall_seq && !part_valid
      |=> !stalled && replay_valid);

   p_replay_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      replay_valid |-> $past(stalled));

   p_foreign_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stalled && done_valid && done_seq != stall_seq |=> stalled);
endmodule

// File: rtl/stlf_checker.sv
module stlf_checker
   import sfc_pkg::*;
#(
   parameter int SQ_DEPTH   = 8,
   parameter int LQ_DEPTH   = 16,
   parameter int ADDR_W     = 16,
   parameter int DATA_BYTES = 8,
   parameter int SEQ_W      = 8,
   localparam int IDX_W     = $clog2(SQ_DEPTH),
   localparam int LQ_W      = $clog2(LQ_DEPTH),
   localparam int SIZE_W    = $clog2(DATA_BYTES) + 1,
   localparam int DATA_W    = DATA_BYTES * 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_valid,
   input  logic [ADDR_W-1:0]          ld_addr,
   input  logic [SIZE_W-1:0]          ld_size,
   input  logic [IDX_W-1:0]           ld_sq_idx,
   input  logic [SEQ_W-1:0]           ld_seq,
   input  logic [LQ_W-1:0]            ld_lq_idx,
   input  logic                       ld_uncache,
   input  logic                       ld_at_head,
   input  logic [IDX_W-1:0]           sq_wb_ptr,
   input  logic [SQ_DEPTH*ADDR_W-1:0] sq_addr,
   input  logic [SQ_DEPTH*SIZE_W-1:0] sq_size,
   input  logic [SQ_DEPTH-1:0]        sq_uncache,
   input  logic [SQ_DEPTH*DATA_W-1:0] sq_data,
   input  logic [SQ_DEPTH*SEQ_W-1:0]  sq_seq,
   input  logic                       done_valid,
   input  logic [SEQ_W-1:0]           done_seq,
   output logic                       fwd_valid,
   output logic [DATA_W-1:0]          fwd_data,
   output logic                       mem_go,
   output logic                       resched,
   output logic                       stalled,
   output logic [SEQ_W-1:0]           stall_seq,
   output logic [LQ_W-1:0]            stall_lq_idx,
   output logic                       replay_valid,
   output logic [LQ_W-1:0]            replay_lq_idx
);
   // elaboration-time parameter checks
   if (SQ_DEPTH < 2 || (SQ_DEPTH & (SQ_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("SQ_DEPTH must be a power of two of at least 2");
   end
   if (DATA_BYTES < 2 || (DATA_BYTES & (DATA_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("DATA_BYTES must be a power of two of at least 2");
   end
   if (LQ_DEPTH < 2) begin : g_bad_lq
      $error("LQ_DEPTH must be at least 2");
   end

   logic                       scan_found;
   hit_kind_e                  scan_kind;
   logic [SEQ_W-1:0]           scan_seq;
   logic [$clog2(DATA_BYTES)-1:0] scan_off;
   logic [DATA_W-1:0]          scan_data;

   sfc_scan #(
      .DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
      .DATA_BYTES(DATA_BYTES), .SEQ_W(SEQ_W)
   ) u_scan (
      .ld_addr  (ld_addr),
      .ld_size  (ld_size),
      .start_idx(ld_sq_idx),
      .wb_ptr   (sq_wb_ptr),
      .sq_addr_f(sq_addr),
      .sq_size_f(sq_size),
      .sq_unc   (sq_uncache),
      .sq_data_f(sq_data),
      .sq_seq_f (sq_seq),
      .found    (scan_found),
      .kind     (scan_kind),
      .hit_seq  (scan_seq),
      .off      (scan_off),
      .fwd_data (scan_data)
   );

   // R8: uncacheable loads away from the head are bounced before the search
   logic hold_unc, searched, fwd_d, part_d, mem_d;
   assign hold_unc = ld_valid && ld_uncache && !ld_at_head;
   assign searched = ld_valid && !hold_unc;
   assign fwd_d    = searched && scan_found && scan_kind == HIT_FULL;
   assign part_d   = searched && scan_found && scan_kind == HIT_PART;
   assign mem_d    = searched && !scan_found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_valid <= 1'b0;
         fwd_data  <= '0;
         mem_go    <= 1'b0;
         resched   <= 1'b0;
      end else begin
         fwd_valid <= fwd_d;
         fwd_data  <= fwd_d ? scan_data : '0;
         mem_go    <= mem_d;
         resched   <= part_d || hold_unc;
      end
   end

   sfc_stall_track #(.SEQ_W(SEQ_W), .LQ_W(LQ_W)) u_stall (
      .clk          (clk),
      .rst_n        (rst_n),
      .part_valid   (part_d),
      .part_ld_seq  (ld_seq),
      .part_lq_idx  (ld_lq_idx),
      .part_st_seq  (scan_seq),
      .done_valid   (done_valid),
      .done_seq     (done_seq),
      .stalled      (stalled),
      .stall_seq    (stall_seq),
      .stall_lq_idx (stall_lq_idx),
      .replay_valid (replay_valid),
      .replay_lq_idx(replay_lq_idx)
   );

   p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> $countones({fwd_valid, mem_go, resched}) == 1);

   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |=> !fwd_valid && !mem_go && !resched);

   p_unc_bounce_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid && ld_uncache && !ld_at_head |=> resched && !mem_go && !fwd_valid);

   p_fwd_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid && scan_found && scan_kind == HIT_FULL
      |-> int'(scan_off) + int'(ld_size) <= DATA_BYTES);

   p_empty_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid && !ld_uncache && ld_sq_idx == sq_wb_ptr |=> mem_go);

   p_stall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stalled) |-> $past(resched == 1'b0) && resched);
endmodule

// File: tb/stlf_checker_test.sv
`timescale 1ns/1ps
module stlf_checker_test;
   localparam int D = 8;

   typedef struct packed {
      logic [2:0]  idx;
      logic [2:0]  wb;
      logic [15:0] addr;
      logic [3:0]  size;
      logic        fwd;
      logic [63:0] data;
   } vec_t;

   // fwd=1: expect forwarding with data; fwd=0: expect memory access
   localparam vec_t VEC [10] = '{
      '{3'd2, 3'd0, 16'h0104, 4'd4, 1'b1, 64'h13121110},  // R3 own slot
      '{3'd1, 3'd0, 16'h0104, 4'd4, 1'b1, 64'h07060504},  // R3 offset 4
      '{3'd4, 3'd0, 16'h0200, 4'd4, 1'b0, 64'h0},         // R2 skips
      '{3'd0, 3'd4, 16'h0302, 4'd2, 1'b1, 64'h5150},      // R1 wrap
      '{3'd0, 3'd6, 16'h0302, 4'd2, 1'b0, 64'h0},         // R1 wb cut
      '{3'd3, 3'd3, 16'h0104, 4'd4, 1'b0, 64'h0},         // R1 empty
      '{3'd6, 3'd4, 16'h0300, 4'd2, 1'b1, 64'h4140},      // R3 adjacent
      '{3'd6, 3'd4, 16'h0305, 4'd2, 1'b1, 64'h4645},      // R3 offset 5
      '{3'd1, 3'd0, 16'h0100, 4'd1, 1'b1, 64'h00},        // R3 one byte
      '{3'd2, 3'd0, 16'h0106, 4'd2, 1'b1, 64'h1312}       // R4 nearest
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic ld_valid = 0, ld_uncache = 0, ld_at_head = 0, done_valid = 0;
   logic [15:0] ld_addr = '0;
   logic [3:0]  ld_size = '0, ld_lq_idx = '0;
   logic [2:0]  ld_sq_idx = '0, sq_wb_ptr = '0;
   logic [7:0]  ld_seq = '0, done_seq = '0;
   logic [D*16-1:0] sq_addr;
   logic [D*4-1:0]  sq_size;
   logic [D-1:0]    sq_uncache;
   logic [D*64-1:0] sq_data;
   logic [D*8-1:0]  sq_seq;
   logic fwd_valid, mem_go, resched, stalled, replay_valid;
   logic [63:0] fwd_data;
   logic [7:0]  stall_seq;
   logic [3:0]  stall_lq_idx, replay_lq_idx;

   int checks = 0, failures = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   stlf_checker uut (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
      .ld_size(ld_size), .ld_sq_idx(ld_sq_idx), .ld_seq(ld_seq),
      .ld_lq_idx(ld_lq_idx), .ld_uncache(ld_uncache), .ld_at_head(ld_at_head),
      .sq_wb_ptr(sq_wb_ptr), .sq_addr(sq_addr), .sq_size(sq_size),
      .sq_uncache(sq_uncache), .sq_data(sq_data), .sq_seq(sq_seq),
      .done_valid(done_valid), .done_seq(done_seq), .fwd_valid(fwd_valid),
      .fwd_data(fwd_data), .mem_go(mem_go), .resched(resched),
      .stalled(stalled), .stall_seq(stall_seq), .stall_lq_idx(stall_lq_idx),
      .replay_valid(replay_valid), .replay_lq_idx(replay_lq_idx)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] idx, input logic [2:0] wb,
                        input logic [15:0] a, input logic [3:0] sz,
                        input logic [7:0] seq, input logic [3:0] lq,
                        input logic unc, input logic head);
      @(negedge clk);
      ld_sq_idx = idx; sq_wb_ptr = wb; ld_addr = a; ld_size = sz;
      ld_seq = seq; ld_lq_idx = lq; ld_uncache = unc; ld_at_head = head;
      ld_valid = 1'b1;
      @(negedge clk);
      ld_valid = 1'b0; ld_uncache = 1'b0; ld_at_head = 1'b0;
   endtask

   task automatic complete(input logic [7:0] seq);
      @(negedge clk);
      done_valid = 1'b1; done_seq = seq;
      @(negedge clk);
      done_valid = 1'b0;
   endtask

   initial begin
      // slot s: data byte j = {s,j}, sequence 0x10+s
      sq_uncache = '0;
      for (int s = 0; s < D; s++) begin
         sq_seq[s*8 +: 8] = 8'(8'h10 + s);
         for (int j = 0; j < 8; j++) sq_data[s*64 + j*8 +: 8] = 8'((s << 4) | j);
      end
      sq_addr[0*16 +: 16] = 16'h0100; sq_size[0*4 +: 4] = 4'd8;
      sq_addr[1*16 +: 16] = 16'h0104; sq_size[1*4 +: 4] = 4'd4;
      sq_addr[2*16 +: 16] = 16'h0200; sq_size[2*4 +: 4] = 4'd8; sq_uncache[2] = 1'b1;
      sq_addr[3*16 +: 16] = 16'h0200; sq_size[3*4 +: 4] = 4'd0;
      sq_addr[4*16 +: 16] = 16'h0300; sq_size[4*4 +: 4] = 4'd8;
      sq_addr[5*16 +: 16] = 16'h0302; sq_size[5*4 +: 4] = 4'd2;
      sq_addr[6*16 +: 16] = 16'h0400; sq_size[6*4 +: 4] = 4'd4;
      sq_addr[7*16 +: 16] = 16'h0500; sq_size[7*4 +: 4] = 4'd8;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check("R10 outputs", {fwd_valid, mem_go, resched, stalled, replay_valid}, 0);
      check("R10 data", fwd_data, 0);

      // table walk: R1 R2 R3 R4 R6
      for (int v = 0; v < 10; v++) begin
         issue(VEC[v].idx, VEC[v].wb, VEC[v].addr, VEC[v].size, 8'h20, 4'd0, 1'b0, 1'b0);
         check($sformatf("R3 fwd_valid vec%0d", v), fwd_valid, VEC[v].fwd);
         check($sformatf("R6 mem_go vec%0d", v), mem_go, !VEC[v].fwd);
         check($sformatf("R3 data vec%0d", v), fwd_data, VEC[v].data);
         check($sformatf("R2 no resched vec%0d", v), resched, 0);
      end
      @(negedge clk);
      check("R11 pulse ends", {fwd_valid, mem_go, resched}, 0);

      // R8: uncacheable load away from head is bounced
      issue(3'd2, 3'd0, 16'h0104, 4'd4, 8'h20, 4'd2, 1'b1, 1'b0);
      check("R8 resched", {fwd_valid, mem_go, resched}, 3'b001);
      check("R8 no stall", stalled, 0);
      // R8: at head it is searched
      issue(3'd2, 3'd0, 16'h0104, 4'd4, 8'h20, 4'd2, 1'b1, 1'b1);
      check("R8 head fwd", {fwd_valid, mem_go, resched}, 3'b100);

      // R5: partial overlap with slot 1
      issue(3'd2, 3'd0, 16'h0102, 4'd4, 8'h40, 4'd3, 1'b0, 1'b0);
      check("R5 outcome", {fwd_valid, mem_go, resched}, 3'b001);
      check("R5 stalled", stalled, 1);
      check("R5 stall_seq", stall_seq, 8'h11);
      check("R5 lq", stall_lq_idx, 4'd3);

      // R7: younger partial leaves record
      issue(3'd6, 3'd4, 16'h0301, 4'd2, 8'h50, 4'd5, 1'b0, 1'b0);
      check("R7 younger resched", resched, 1);
      check("R7 younger seq", stall_seq, 8'h11);
      check("R7 younger lq", stall_lq_idx, 4'd3);
      // R7: older partial replaces record
      issue(3'd6, 3'd4, 16'h0301, 4'd2, 8'h30, 4'd1, 1'b0, 1'b0);
      check("R7 older seq", stall_seq, 8'h15);
      check("R7 older lq", stall_lq_idx, 4'd1);

      // R9: foreign completion ignored
      complete(8'h11);
      check("R9 foreign stalled", stalled, 1);
      check("R9 foreign replay", replay_valid, 0);
      // R9: matching completion releases
      complete(8'h15);
      check("R9 released", stalled, 0);
      check("R9 replay", replay_valid, 1);
      check("R9 replay lq", replay_lq_idx, 4'd1);
      @(negedge clk);
      check("R9 replay pulse", replay_valid, 0);

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule